// File: doc/BRIEF.md
# Block Copy DMA Engine

A single-channel engine that copies a block of elements from a source address range to a destination address range. Software sets it up through five 32-bit registers on a simple write/read register port. A status write with the start bit set launches the transfer. The engine then moves data over two master streams: a read stream that fetches elements and a write stream that stores them. Each element is 1, 2 or 4 bytes wide and always sits in the low lanes of the 32-bit data bus.

Either side can hold its address fixed, which suits a port that behaves like a FIFO. When burst mode is on, the engine moves data in groups of 4, 8, 16 or 32 beats. It reads the whole group into an internal holding buffer and then writes the group out. When the bytes left cannot fill a whole burst, it finishes the tail with single-beat groups.

Both master streams use valid/ready. The engine raises valid with the address, and also the data on the write side. It then holds every field steady until the beat where ready is high. That beat is the only one that completes a transfer, so the slave can apply back-pressure for as long as it likes. The read data is taken in the same beat that the handshake completes.

Top module: `blk_copy_dma`

## Requirements
- R1: The register port decodes byte offsets. Offset 0x00 is the source address, 0x04 the destination address and 0x08 the byte length; each holds 32 bits and reads back as written. Offset 0x0C is control and keeps bits 6:0 only. Offset 0x10 is status.
- R2: Status fields are: bit 0 busy (read-only), bit 1 interrupt enable, bit 2 success, and bit 3 start (write-only, reads 0). After reset, every register reads 0. A status write with bit 3 set while idle latches the setup, clears success, and makes busy read 1 from the next cycle.
- R3: A start write while busy has no effect. Setup registers rewritten during a transfer do not change that transfer.
- R4: Control bits 3 and 2 choose the element width: bit 3 gives 4 bytes, else bit 2 gives 2 bytes, else 1 byte. Output rd_size/wr_size carries 0, 1 or 2 to match. Bytes of read data above the element width are written as zero.
- R5: Control bit 0 keeps the source address fixed and control bit 1 keeps the destination address fixed. Any other address advances by the element width after each handshake, starting from the programmed value.
- R6: Control bit 6 enables burst mode, and control bits 5:4 pick the burst size: 00 gives 4 beats, 01 gives 8, 10 gives 16 and 11 gives 32. A group is a full burst when the remaining bytes are at least one full burst, and a single beat otherwise. The beats output carries the group size. The last output marks the final beat of the group.
- R7: Within a group, every read completes before the first write. Data is written in the order it was read. Reads and writes are never valid in the same cycle.
- R8: A valid beat that is not accepted stays valid the next cycle, with its address, last flag and write data unchanged.
- R9: When the last element is written, busy clears and success sets in the same clock edge.
- R10: A start with length 0, or with a length that is not a multiple of the element width, produces no bus traffic. Busy never rises and success stays 0.
- R11: Any completion (R9 or R10) with interrupt enable set drives irq to 1. Irq stays 1 until a status write with bit 2 equal to 0; such a write also clears success. A status write with bit 2 equal to 1 leaves both irq and success unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| rd_valid | output | 1 | Read beat request valid |
| rd_ready | input | 1 | Read beat accepted, rd_data valid |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Element width code |
| rd_beats | output | 6 | Beats in current read group |
| rd_last | output | 1 | Final beat of read group |
| rd_data | input | DATA_W | Read data, element in low lanes |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_size | output | 2 | Element width code |
| wr_beats | output | 6 | Beats in current write group |
| wr_last | output | 1 | Final beat of write group |
| wr_data | output | DATA_W | Write data, element in low lanes |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |

## Verification
The copy is tried with each element width on incrementing addresses, with a fixed source, and with a fixed destination. Comparing the destination memory against a model separates correct stepping and masking from wrong ones. Burst setups cover every size code. They include lengths that fill whole bursts exactly, lengths that need a single-beat tail, and lengths too short for any burst; the burst and single beat counts show whether the group split is right. Ready patterns range from always-ready to rarely-ready, which exposes beats lost or duplicated under back-pressure. Zero and misaligned lengths, a start during a busy run, and the interrupt clear rules are tested as directed cases.

// File: rtl/blk_copy_dma_pkg.sv
package blk_copy_dma_pkg;

  localparam int REG_W     = 32;
  localparam int MAX_BEATS = 32;
  localparam int BEAT_W    = $clog2(MAX_BEATS) + 1;
  localparam int IDX_W     = $clog2(MAX_BEATS);

  localparam int ST_BUSY = 0;
  localparam int ST_IE   = 1;
  localparam int ST_OK   = 2;
  localparam int ST_GO   = 3;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2
  } esz_e;

  // Packed so member order matches control bit positions 6..0.
  typedef struct packed {
    logic       burst_en;
    logic [1:0] burst_code;
    logic       word;
    logic       half;
    logic       dst_fix;
    logic       src_fix;
  } ctrl_t;

  function automatic esz_e elem_code(ctrl_t c);
    if (c.word) return ESZ_WORD;
    if (c.half) return ESZ_HALF;
    return ESZ_BYTE;
  endfunction

  function automatic logic [2:0] elem_bytes(esz_e e);
    return 3'd1 << e;
  endfunction

  function automatic logic [BEAT_W-1:0] burst_beats(logic [1:0] code);
    return BEAT_W'(4) << code;
  endfunction

  // Beats in the next group given the bytes still to move.
  function automatic logic [BEAT_W-1:0] group_size(logic [REG_W-1:0] rem, ctrl_t c);
    logic [REG_W-1:0] span;
    span = REG_W'(burst_beats(c.burst_code)) << elem_code(c);
    if (c.burst_en && rem >= span) return burst_beats(c.burst_code);
    return BEAT_W'(1);
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import blk_copy_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [4:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              busy,
  input  logic              done_ok,
  output logic              launch,
  output logic [ADDR_W-1:0] prog_src,
  output logic [ADDR_W-1:0] prog_dst,
  output logic [REG_W-1:0]  prog_len,
  output ctrl_t             prog_ctrl,
  output logic              irq
);

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_LEN  = 3'd2;
  localparam logic [2:0] SEL_CTL  = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  logic       ie_q, ok_q, irq_q;
  logic       wr_stat, start_req, len_bad, start_bad;
  logic [2:0] ebytes;

  assign wr_stat   = cfg_wr_en && (cfg_addr[4:2] == SEL_STAT);
  assign start_req = wr_stat && cfg_wdata[ST_GO] && !busy;
  assign ebytes    = elem_bytes(elem_code(prog_ctrl));
  assign len_bad   = (prog_len == '0) ||
                     ((prog_len & REG_W'(ebytes - 3'd1)) != '0);
  assign launch    = start_req && !len_bad;
  assign start_bad = start_req && len_bad;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_src  <= '0;
      prog_dst  <= '0;
      prog_len  <= '0;
      prog_ctrl <= '0;
      ie_q      <= 1'b0;
      ok_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (cfg_wr_en && cfg_addr[4:2] == SEL_SRC) prog_src  <= cfg_wdata[ADDR_W-1:0];
      if (cfg_wr_en && cfg_addr[4:2] == SEL_DST) prog_dst  <= cfg_wdata[ADDR_W-1:0];
      if (cfg_wr_en && cfg_addr[4:2] == SEL_LEN) prog_len  <= cfg_wdata;
      if (cfg_wr_en && cfg_addr[4:2] == SEL_CTL) prog_ctrl <= ctrl_t'(cfg_wdata[6:0]);
      if (wr_stat) begin
        ie_q <= cfg_wdata[ST_IE];
        if (!cfg_wdata[ST_OK]) begin
          ok_q  <= 1'b0;
          irq_q <= 1'b0;
        end
      end
      if (launch) ok_q <= 1'b0;
      if (start_bad) begin
        ok_q  <= 1'b0;
        irq_q <= cfg_wdata[ST_IE];
      end
      if (done_ok) begin
        ok_q <= 1'b1;
        if (ie_q) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr[4:2])
      SEL_SRC:  cfg_rdata = REG_W'(prog_src);
      SEL_DST:  cfg_rdata = REG_W'(prog_dst);
      SEL_LEN:  cfg_rdata = prog_len;
      SEL_CTL:  cfg_rdata = REG_W'(prog_ctrl);
      SEL_STAT: begin
        cfg_rdata[ST_BUSY] = busy;
        cfg_rdata[ST_IE]   = ie_q;
        cfg_rdata[ST_OK]   = ok_q;
      end
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_hold_buf.sv
module dma_hold_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);

  logic [DATA_W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import blk_copy_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] prog_src,
  input  logic [ADDR_W-1:0] prog_dst,
  input  logic [REG_W-1:0]  prog_len,
  input  ctrl_t             prog_ctrl,
  output logic              busy,
  output logic              done_ok,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  output logic [BEAT_W-1:0] rd_beats,
  output logic              rd_last,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [BEAT_W-1:0] wr_beats,
  output logic              wr_last,
  output logic [DATA_W-1:0] wr_data
);

  localparam int LANES = DATA_W / 8;

  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

  mv_state_e         state;
  logic [ADDR_W-1:0] cur_src, cur_dst;
  logic [REG_W-1:0]  rem;
  ctrl_t             ctl;
  logic [BEAT_W-1:0] grp_beats;
  logic [IDX_W-1:0]  idx;

  esz_e              esz;
  logic [2:0]        ebytes;
  logic              last_beat, rd_fire, wr_fire, final_elem;
  logic [DATA_W-1:0] rd_masked;

  assign esz        = elem_code(ctl);
  assign ebytes     = elem_bytes(esz);
  assign last_beat  = (BEAT_W'(idx) == grp_beats - BEAT_W'(1));
  assign busy       = (state != MV_IDLE);
  assign rd_valid   = (state == MV_READ);
  assign wr_valid   = (state == MV_WRITE);
  assign rd_fire    = rd_valid && rd_ready;
  assign wr_fire    = wr_valid && wr_ready;
  assign final_elem = (rem == REG_W'(ebytes));
  assign done_ok    = wr_fire && last_beat && final_elem;

  assign rd_addr  = cur_src;
  assign wr_addr  = cur_dst;
  assign rd_size  = esz;
  assign wr_size  = esz;
  assign rd_beats = grp_beats;
  assign wr_beats = grp_beats;
  assign rd_last  = last_beat;
  assign wr_last  = last_beat;

  always_comb begin
    rd_masked = '0;
    for (int b = 0; b < LANES; b++) begin
      if (b < int'(ebytes)) rd_masked[b*8 +: 8] = rd_data[b*8 +: 8];
    end
  end

  dma_hold_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (MAX_BEATS)
  ) u_hold (
    .clk     (clk),
    .wr_en   (rd_fire),
    .wr_idx  (idx),
    .wr_data (rd_masked),
    .rd_idx  (idx),
    .rd_data (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MV_IDLE;
      cur_src   <= '0;
      cur_dst   <= '0;
      rem       <= '0;
      ctl       <= '0;
      grp_beats <= BEAT_W'(1);
      idx       <= '0;
    end else begin
      unique case (state)
        MV_IDLE: begin
          if (launch) begin
            cur_src   <= prog_src;
            cur_dst   <= prog_dst;
            rem       <= prog_len;
            ctl       <= prog_ctrl;
            grp_beats <= group_size(prog_len, prog_ctrl);
            idx       <= '0;
            state     <= MV_READ;
          end
        end
        MV_READ: begin
          if (rd_fire) begin
            if (!ctl.src_fix) cur_src <= cur_src + ADDR_W'(ebytes);
            if (last_beat) begin
              idx   <= '0;
              state <= MV_WRITE;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        MV_WRITE: begin
          if (wr_fire) begin
            if (!ctl.dst_fix) cur_dst <= cur_dst + ADDR_W'(ebytes);
            rem <= rem - REG_W'(ebytes);
            if (last_beat) begin
              idx <= '0;
              if (final_elem) begin
                state <= MV_IDLE;
              end else begin
                grp_beats <= group_size(rem - REG_W'(ebytes), ctl);
                state     <= MV_READ;
              end
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: state <= MV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blk_copy_dma.sv
module blk_copy_dma
  import blk_copy_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [4:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  output logic [BEAT_W-1:0] rd_beats,
  output logic              rd_last,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [BEAT_W-1:0] wr_beats,
  output logic              wr_last,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              irq
);

  logic              launch, done_ok;
  logic [ADDR_W-1:0] prog_src, prog_dst;
  logic [REG_W-1:0]  prog_len;
  ctrl_t             prog_ctrl;

  dma_cfg_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .done_ok   (done_ok),
    .launch    (launch),
    .prog_src  (prog_src),
    .prog_dst  (prog_dst),
    .prog_len  (prog_len),
    .prog_ctrl (prog_ctrl),
    .irq       (irq)
  );

  dma_mover #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .prog_src  (prog_src),
    .prog_dst  (prog_dst),
    .prog_len  (prog_len),
    .prog_ctrl (prog_ctrl),
    .busy      (busy),
    .done_ok   (done_ok),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_size   (rd_size),
    .rd_beats  (rd_beats),
    .rd_last   (rd_last),
    .rd_data   (rd_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_beats  (wr_beats),
    .wr_last   (wr_last),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/blk_copy_dma_chk.sv
module blk_copy_dma_chk
  import blk_copy_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [4:0]        cfg_addr,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic              busy,
  input logic              irq,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        rd_size,
  input logic [BEAT_W-1:0] rd_beats,
  input logic              rd_last,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_last
);

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_last));

  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_last));

  a_r4_size_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rd_size));

  a_r6_single_last: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_beats == BEAT_W'(1) |-> rd_last);

  a_r6_beats_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($countones(rd_beats) == 1) && (rd_beats <= BEAT_W'(MAX_BEATS)));

  a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cfg_wr_en && cfg_addr[4:2] == 3'd4 && !cfg_wdata[ST_OK]));

endmodule

bind blk_copy_dma blk_copy_dma_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .busy      (busy),
  .irq       (irq),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .rd_size   (rd_size),
  .rd_beats  (rd_beats),
  .rd_last   (rd_last),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_last   (wr_last)
);

// File: tb/test_blk_copy_dma.sv
module test_blk_copy_dma;
  import blk_copy_dma_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_valid, rd_last, wr_valid, wr_last, busy, irq;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr, rd_data, wr_data;
  logic [1:0]  rd_size, wr_size;
  logic [5:0]  rd_beats, wr_beats;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  blk_copy_dma i_blk_copy_dma (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_beats(rd_beats), .rd_last(rd_last), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_beats(wr_beats), .wr_last(wr_last), .wr_data(wr_data),
    .busy(busy), .irq(irq)
  );

  // Vector: src[63:48] dst[47:32] len[31:16] ctrl[15:8] ie[7] ok[6] stall[5:4]
  localparam int NV = 13;
  localparam logic [63:0] VECS [NV] = '{
    64'h0010_0100_000D_00_40,  // byte, incrementing
    64'h0022_0140_0014_04_50,  // half
    64'h0040_0180_0028_08_60,  // word
    64'h0080_0000_0028_48_40,  // word burst 4 + tail
    64'h0005_0031_0015_50_70,  // byte burst 8 + tail
    64'h0000_0080_0040_74_D0,  // half burst 32 exact, ie
    64'h01F0_0040_0010_09_40,  // word fixed source
    64'h0100_01FC_000C_0A_60,  // word fixed destination
    64'h0000_0000_0000_08_80,  // zero length, ie
    64'h0010_0020_0006_08_00,  // misaligned word length
    64'h0003_0101_001E_64_50,  // half burst 16 too short -> all singles
    64'h0000_0000_0080_78_70,  // word burst 32 exact
    64'h0000_0000_0005_04_00   // odd half length
  };

  // Stimulus-side memory and ready patterns
  logic [1:0] stall = 2'd0;
  int cyc = 0;

  function automatic logic [7:0] pat(logic [31:0] a);
    return a[7:0] * 8'd29 + a[15:8] + 8'h5A;
  endfunction

  function automatic logic rdy(logic [1:0] m, int c);
    case (m)
      2'd0: return 1'b1;
      2'd1: return c[0];
      2'd2: return (c % 4) != 0;
      default: return (c % 8) == 5;
    endcase
  endfunction

  always_comb rd_data = {pat(rd_addr + 32'd3), pat(rd_addr + 32'd2), pat(rd_addr + 32'd1), pat(rd_addr)};

  always @(negedge clk) begin
    cyc = cyc + 1;
    rd_ready = rdy(stall, cyc);
    wr_ready = rdy(stall, cyc + 5);
  end

  // Monitor and model state
  logic [7:0]  dmem [512];
  logic [7:0]  emem [512];
  logic [31:0] m_src, m_dst;
  logic [7:0]  m_ctrl;
  int m_esz;
  int n_rd, n_wr, n_rd_burst, n_wr_burst, n_rd_last, n_wr_last, n_addr_bad, n_size_bad;

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin
      if (rd_addr !== m_src + (m_ctrl[0] ? 32'd0 : 32'(n_rd * m_esz))) n_addr_bad++;
      if (rd_size !== 2'($clog2(m_esz))) n_size_bad++;
      if (rd_beats > 6'd1) n_rd_burst++;
      if (rd_last) n_rd_last++;
      n_rd++;
    end
    if (wr_valid && wr_ready) begin
      if (wr_addr !== m_dst + (m_ctrl[1] ? 32'd0 : 32'(n_wr * m_esz))) n_addr_bad++;
      if (wr_size !== 2'($clog2(m_esz))) n_size_bad++;
      for (int b = 0; b < 4; b++)
        if (b < m_esz) dmem[(wr_addr + 32'(b)) & 32'h1FF] = wr_data[b*8 +: 8];
        else if (wr_data[b*8 +: 8] != 8'h00) n_size_bad++;
      if (wr_beats > 6'd1) n_wr_burst++;
      if (wr_last) n_wr_last++;
      n_wr++;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [4:0] a, logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  int e_elems, e_burst, e_groups;

  task automatic setup_model(logic [31:0] s, logic [31:0] d, logic [31:0] len, logic [7:0] c);
    int rem, bb;
    m_src = s; m_dst = d; m_ctrl = c;
    m_esz = c[3] ? 4 : (c[2] ? 2 : 1);
    for (int i = 0; i < 512; i++) begin dmem[i] = 8'h00; emem[i] = 8'h00; end
    n_rd = 0; n_wr = 0; n_rd_burst = 0; n_wr_burst = 0;
    n_rd_last = 0; n_wr_last = 0; n_addr_bad = 0; n_size_bad = 0;
    e_elems = 0; e_burst = 0; e_groups = 0;
    if (len != 0 && (int'(len) % m_esz) == 0) begin
      e_elems = int'(len) / m_esz;
      for (int i = 0; i < e_elems; i++)
        for (int b = 0; b < m_esz; b++)
          emem[(d + (c[1] ? 0 : i * m_esz) + b) & 511] = pat(s + (c[0] ? 0 : i * m_esz) + b);
      rem = int'(len);
      bb = 4 << c[5:4];
      while (rem > 0) begin
        if (c[6] && rem >= bb * m_esz) begin e_burst += bb; rem -= bb * m_esz; end
        else rem -= m_esz;
        e_groups++;
      end
    end
  endtask

  task automatic program_start(logic [31:0] s, logic [31:0] d, logic [31:0] len,
                               logic [7:0] c, logic ie);
    cfg_write(5'h00, s);
    cfg_write(5'h04, d);
    cfg_write(5'h08, len);
    cfg_write(5'h0C, {24'h0, c});
    cfg_write(5'h10, {28'h0, 1'b1, 1'b0, ie, 1'b0});
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
  endtask

  function automatic int mem_diff();
    int bad = 0;
    for (int i = 0; i < 512; i++) if (dmem[i] !== emem[i]) bad++;
    return bad;
  endfunction

  logic [31:0] rv;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    cfg_read(5'h10, rv); check("R2", "status after reset", rv, 0);
    cfg_read(5'h00, rv); check("R2", "source after reset", rv, 0);
    check("R2", "busy/irq/valids after reset", {busy, irq, rd_valid, wr_valid}, 0);

    // R1: readback of setup registers
    cfg_write(5'h00, 32'h1234_5678); cfg_read(5'h00, rv); check("R1", "source readback", rv, 32'h1234_5678);
    cfg_write(5'h04, 32'h9ABC_DEF0); cfg_read(5'h04, rv); check("R1", "dest readback", rv, 32'h9ABC_DEF0);
    cfg_write(5'h08, 32'h0000_0404); cfg_read(5'h08, rv); check("R1", "length readback", rv, 32'h404);
    cfg_write(5'h0C, 32'hFFFF_FFFF); cfg_read(5'h0C, rv); check("R1", "control keeps 7 bits", rv, 32'h7F);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [63:0] e;
      e = VECS[v];
      stall = e[5:4];
      setup_model({16'h0, e[63:48]}, {16'h0, e[47:32]}, {16'h0, e[31:16]}, e[15:8]);
      program_start({16'h0, e[63:48]}, {16'h0, e[47:32]}, {16'h0, e[31:16]}, e[15:8], e[7]);
      cfg_read(5'h10, rv);
      check("R2", $sformatf("v%0d busy/start bits after start", v), {rv[3], rv[0]}, {1'b0, e[6]});
      check("R2", $sformatf("v%0d success cleared at start", v), rv[2], 0);
      wait_idle();
      cfg_read(5'h10, rv);
      check("R9", $sformatf("v%0d success", v), rv[2], e[6]);
      check("R11", $sformatf("v%0d irq", v), irq, e[7]);
      check("R7", $sformatf("v%0d dest bytes wrong", v), mem_diff(), 0);
      check("R5", $sformatf("v%0d address steps wrong", v), n_addr_bad, 0);
      check("R4", $sformatf("v%0d size or masking wrong", v), n_size_bad, 0);
      check("R10", $sformatf("v%0d reads/writes", v), {n_rd, n_wr}, {e_elems, e_elems});
      check("R6", $sformatf("v%0d burst beats rd/wr", v), {n_rd_burst, n_wr_burst}, {e_burst, e_burst});
      check("R6", $sformatf("v%0d groups rd/wr", v), {n_rd_last, n_wr_last}, {e_groups, e_groups});
      cfg_write(5'h10, 32'h0);
    end

    // R3: start and setup writes while busy are ignored by the running copy
    stall = 2'd3;
    setup_model(32'h0, 32'h100, 32'd64, 8'h08);
    program_start(32'h0, 32'h100, 32'd64, 8'h08, 1'b0);
    repeat (10) @(negedge clk);
    cfg_write(5'h08, 32'd4);
    cfg_write(5'h00, 32'h1F0);
    cfg_write(5'h10, 32'h8);
    wait_idle();
    repeat (20) @(negedge clk);
    check("R3", "reads after start-while-busy", n_rd, 16);
    check("R3", "dest after start-while-busy", mem_diff(), 0);
    check("R3", "busy stays low", busy, 0);
    cfg_write(5'h10, 32'h0);

    // R11: irq hold and clear rules
    stall = 2'd0;
    setup_model(32'h20, 32'h60, 32'd8, 8'h00);
    program_start(32'h20, 32'h60, 32'd8, 8'h00, 1'b1);
    wait_idle();
    check("R11", "irq after completion", irq, 1);
    cfg_write(5'h10, 32'h6);
    cfg_read(5'h10, rv);
    check("R11", "irq/success after write with success=1", {irq, rv[2]}, 2'b11);
    cfg_write(5'h10, 32'h2);
    cfg_read(5'h10, rv);
    check("R11", "irq/status after write with success=0", {irq, rv[3:0]}, 5'b0_0010);
    cfg_write(5'h10, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule